// File: doc/BRIEF.md
# Burst-of-Two Separate-Port SRAM Core

This block models a synchronous SRAM that has independent read and write ports. Each command carries a fixed two-beat burst. The external data bus is half as wide as an array word. A write gathers two input beats, each with its own byte enables, and commits them to the array as one wide word. A read fetches one wide word and returns it as two consecutive beats on the output bus, together with a valid strobe. The read data appears two command cycles after the read command.

Double data rate is modelled with a single beat clock that runs at twice the command rate. An internal slot bit alternates on every beat edge. The first of each pair of edges is the command slot, where commands and the first write beat are sampled. The second is the tail slot, where the second write beat is sampled. The slot bit is exported so the surrounding logic can align to it.

Reads and writes are coherent. A read returns every write whose command was accepted in the same command cycle as the read or in an earlier one, even while that write is still being assembled. Later writes have no effect on the read.

Top module: `b2q_sram`

## Requirements
- R1: A read and a write may be issued in the same command slot; both complete, and the read returns data for its own address.
- R2: A write takes its first beat from `wr_data`/`wr_be` at the command-slot edge where `wr_req` is high, takes its second beat at the following tail-slot edge, and stores both as one array word.
- R3: The first beat of a burst occupies bits [DATA_W-1:0] of the array word and the second beat occupies the upper half, for both writes and reads.
- R4: `wr_be` is active high and sampled with each beat. Bit i enables byte i (bits 8i+7:8i) of that beat. A disabled byte keeps its previous array content.
- R5: A read accepted at command-slot edge N drives its first beat from edge N+4 until edge N+5 and its second beat from edge N+5 until edge N+6, counted in beat-clock edges.
- R6: A read accepted in the same command slot as a write to the same address, or in a later one, returns the merged new bytes. A read accepted one command slot before such a write returns the old contents.
- R7: `rd_valid` is high for exactly the two beats of each read burst and low otherwise.
- R8: While `rd_valid` is low, `rd_data` is zero.
- R9: Reads accepted in consecutive command slots produce an uninterrupted stream of beats with `rd_valid` held high.
- R10: Synchronous active-high `rst` sets `beat_phase` to 0 and clears `rd_valid` and `rd_data`. It discards any read or write in flight and leaves the array contents unchanged.
- R11: `beat_phase` is 0 during a command slot and 1 during a tail slot, and it toggles on every beat-clock edge outside reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Beat clock, twice the command rate |
| rst | input | 1 | Synchronous active-high reset |
| rd_req | input | 1 | Read command, sampled in the command slot |
| rd_addr | input | ADDR_W | Read word address |
| wr_req | input | 1 | Write command, sampled in the command slot |
| wr_addr | input | ADDR_W | Write word address |
| wr_data | input | DATA_W | Write beat data |
| wr_be | input | DATA_W/8 | Per-byte write enables for the current beat |
| rd_data | output | DATA_W | Read beat data, zero when idle |
| rd_valid | output | 1 | High while a read beat is driven |
| beat_phase | output | 1 | 0 in the command slot, 1 in the tail slot |

## Verification
Several properties are checked on every cycle:
- each write command produces a commit in the following tail slot;
- an accepted read always produces a valid beat exactly four beat edges later;
- a valid burst always begins in the tail slot and lasts two beats;
- the output bus is zero whenever valid is low.

Other behaviour is shown only by the bench scenarios, which compare against a byte-level model. These cover:
- beat ordering within the word;
- byte-enable merging;
- the coherence boundary between a read and a write in the same slot or the following one;
- gap-free back-to-back bursts;
- an array that survives a reset which drops a half-assembled write.

// File: rtl/b2q_pkg.sv
`timescale 1ns/1ps
package b2q_pkg;

    localparam int BYTE_W = 8;

    // Position inside one command period of the beat clock
    typedef enum logic {
        SLOT_CMD  = 1'b0,
        SLOT_TAIL = 1'b1
    } slot_e;

    function automatic int lane_count(input int width);
        return width / BYTE_W;
    endfunction

endpackage

// File: rtl/b2q_slot_gen.sv
`timescale 1ns/1ps
module b2q_slot_gen
    import b2q_pkg::*;
(
    input  logic  clk,
    input  logic  rst,
    output slot_e slot
);

    always_ff @(posedge clk) begin
        if (rst) slot <= SLOT_CMD;
        else     slot <= (slot == SLOT_CMD) ? SLOT_TAIL : SLOT_CMD;
    end

    AST_SLOT_ALTERNATES: assert property (@(posedge clk) disable iff (rst)
        (slot == SLOT_CMD) |=> (slot == SLOT_TAIL)); // R11

endmodule

// File: rtl/b2q_wr_gather.sv
`timescale 1ns/1ps
module b2q_wr_gather
    import b2q_pkg::*;
#(
    parameter int DATA_W = 16,
    parameter int ADDR_W = 4,
    localparam int WORD_W = 2 * DATA_W,
    localparam int BE_W   = lane_count(DATA_W)
) (
    input  logic                clk,
    input  logic                rst,
    input  slot_e               slot,
    input  logic                wr_req,
    input  logic [ADDR_W-1:0]   wr_addr,
    input  logic [DATA_W-1:0]   wr_data,
    input  logic [BE_W-1:0]     wr_be,
    output logic                commit_en,
    output logic [ADDR_W-1:0]   commit_addr,
    output logic [WORD_W-1:0]   commit_data,
    output logic [2*BE_W-1:0]   commit_be
);

    logic              pend_v;
    logic [ADDR_W-1:0] pend_addr;
    logic [DATA_W-1:0] lo_data;
    logic [BE_W-1:0]   lo_be;

    // First beat travels with the command
    always_ff @(posedge clk) begin
        if (rst) begin
            pend_v    <= 1'b0;
            pend_addr <= '0;
            lo_data   <= '0;
            lo_be     <= '0;
        end else if (slot == SLOT_CMD) begin
            pend_v    <= wr_req;
            pend_addr <= wr_addr;
            lo_data   <= wr_data;
            lo_be     <= wr_be;
        end
    end

    // Second beat is joined live in the tail slot
    always_comb begin
        commit_en   = pend_v && (slot == SLOT_TAIL) && !rst;
        commit_addr = pend_addr;
        commit_data = {wr_data, lo_data};
        commit_be   = {wr_be, lo_be};
    end

    AST_WRITE_COMMITS: assert property (@(posedge clk) disable iff (rst)
        (wr_req && slot == SLOT_CMD) |=> commit_en); // R2

endmodule

// File: rtl/b2q_array.sv
`timescale 1ns/1ps
module b2q_array
    import b2q_pkg::*;
#(
    parameter int WORD_W = 32,
    parameter int ADDR_W = 4,
    localparam int LANES = lane_count(WORD_W),
    localparam int DEPTH = 1 << ADDR_W
) (
    input  logic              clk,
    input  logic              we,
    input  logic [ADDR_W-1:0] waddr,
    input  logic [WORD_W-1:0] wdata,
    input  logic [LANES-1:0]  wbe,
    input  logic              re,
    input  logic [ADDR_W-1:0] raddr,
    output logic [WORD_W-1:0] rdata
);

    for (genvar g = 0; g < LANES; g++) begin : g_lane
        logic [BYTE_W-1:0] cells [DEPTH];
        logic [BYTE_W-1:0] q_r;

        always_ff @(posedge clk) begin
            if (we && wbe[g]) cells[waddr] <= wdata[g*BYTE_W +: BYTE_W];
            if (re)           q_r          <= cells[raddr];
        end

        assign rdata[g*BYTE_W +: BYTE_W] = q_r;
    end

endmodule

// File: rtl/b2q_rd_path.sv
`timescale 1ns/1ps
module b2q_rd_path
    import b2q_pkg::*;
#(
    parameter int DATA_W = 16,
    parameter int ADDR_W = 4,
    localparam int WORD_W = 2 * DATA_W
) (
    input  logic              clk,
    input  logic              rst,
    input  slot_e             slot,
    input  logic              rd_req,
    input  logic [ADDR_W-1:0] rd_addr,
    output logic              arr_re,
    output logic [ADDR_W-1:0] arr_raddr,
    input  logic [WORD_W-1:0] arr_rdata,
    output logic [DATA_W-1:0] rd_data,
    output logic              rd_valid
);

    logic              a_v;
    logic [ADDR_W-1:0] a_addr;
    logic              b_v;
    logic              h_v;
    logic [DATA_W-1:0] hi_q;

    // Array fetch one command period after acceptance
    assign arr_re    = a_v && (slot == SLOT_CMD) && !rst;
    assign arr_raddr = a_addr;

    always_ff @(posedge clk) begin
        if (rst) begin
            a_v      <= 1'b0;
            a_addr   <= '0;
            b_v      <= 1'b0;
            h_v      <= 1'b0;
            hi_q     <= '0;
            rd_data  <= '0;
            rd_valid <= 1'b0;
        end else if (slot == SLOT_CMD) begin
            a_v      <= rd_req;
            a_addr   <= rd_addr;
            b_v      <= a_v;
            h_v      <= b_v;
            hi_q     <= arr_rdata[WORD_W-1:DATA_W];
            rd_data  <= b_v ? arr_rdata[DATA_W-1:0] : '0;
            rd_valid <= b_v;
        end else begin
            rd_data  <= h_v ? hi_q : '0;
            rd_valid <= h_v;
        end
    end

    AST_READ_LATENCY: assert property (@(posedge clk) disable iff (rst)
        (a_v && slot == SLOT_TAIL) |-> ##4 rd_valid); // R5
    AST_BURST_TWO_BEATS: assert property (@(posedge clk) disable iff (rst)
        (rd_valid && slot == SLOT_TAIL) |=> rd_valid); // R7
    AST_BURST_START_SLOT: assert property (@(posedge clk) disable iff (rst)
        $rose(rd_valid) |-> (slot == SLOT_TAIL)); // R7
    AST_IDLE_ZERO: assert property (@(posedge clk) disable iff (rst)
        !rd_valid |-> (rd_data == '0)); // R8

endmodule

// File: rtl/b2q_sram.sv
`timescale 1ns/1ps
module b2q_sram
    import b2q_pkg::*;
#(
    parameter int DATA_W = 16,
    parameter int ADDR_W = 4,
    localparam int WORD_W = 2 * DATA_W,
    localparam int BE_W   = lane_count(DATA_W)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              rd_req,
    input  logic [ADDR_W-1:0] rd_addr,
    input  logic              wr_req,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [DATA_W-1:0] wr_data,
    input  logic [BE_W-1:0]   wr_be,
    output logic [DATA_W-1:0] rd_data,
    output logic              rd_valid,
    output logic              beat_phase
);

    slot_e             slot;
    logic              c_en;
    logic [ADDR_W-1:0] c_addr;
    logic [WORD_W-1:0] c_data;
    logic [2*BE_W-1:0] c_be;
    logic              r_en;
    logic [ADDR_W-1:0] r_addr;
    logic [WORD_W-1:0] r_data;

    assign beat_phase = slot;

    b2q_slot_gen u_slot (
        .clk  (clk),
        .rst  (rst),
        .slot (slot)
    );

    b2q_wr_gather #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_wr (
        .clk         (clk),
        .rst         (rst),
        .slot        (slot),
        .wr_req      (wr_req),
        .wr_addr     (wr_addr),
        .wr_data     (wr_data),
        .wr_be       (wr_be),
        .commit_en   (c_en),
        .commit_addr (c_addr),
        .commit_data (c_data),
        .commit_be   (c_be)
    );

    b2q_array #(.WORD_W(WORD_W), .ADDR_W(ADDR_W)) u_arr (
        .clk   (clk),
        .we    (c_en),
        .waddr (c_addr),
        .wdata (c_data),
        .wbe   (c_be),
        .re    (r_en),
        .raddr (r_addr),
        .rdata (r_data)
    );

    b2q_rd_path #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_rd (
        .clk       (clk),
        .rst       (rst),
        .slot      (slot),
        .rd_req    (rd_req),
        .rd_addr   (rd_addr),
        .arr_re    (r_en),
        .arr_raddr (r_addr),
        .arr_rdata (r_data),
        .rd_data   (rd_data),
        .rd_valid  (rd_valid)
    );

    // Commit and fetch must never share an edge (coherence by slot separation)
    AST_NO_SAME_EDGE: assert property (@(posedge clk) disable iff (rst)
        !(c_en && r_en)); // R6

endmodule

// File: tb/b2q_sram_tb_top.sv
`timescale 1ns/1ps
module b2q_sram_tb_top;

    localparam int DW = 16;
    localparam int AW = 4;

    typedef struct {
        int          t;
        logic [15:0] d;
        string       tag;
    } exp_t;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          rd_req = 1'b0;
    logic [AW-1:0] rd_addr = '0;
    logic          wr_req = 1'b0;
    logic [AW-1:0] wr_addr = '0;
    logic [DW-1:0] wr_data = '0;
    logic [1:0]    wr_be = '0;
    logic [DW-1:0] rd_data;
    logic          rd_valid;
    logic          beat_phase;

    int   edge_cnt = 0;
    int   n_chk = 0;
    int   n_fail = 0;
    bit   run = 1'b0;
    exp_t q[$];
    logic [15:0] mlo [16];
    logic [15:0] mhi [16];

    always #2.5 clk = ~clk;
    always @(posedge clk) edge_cnt <= edge_cnt + 1;

    b2q_sram #(.DATA_W(DW), .ADDR_W(AW)) dut_i (
        .clk        (clk),
        .rst        (rst),
        .rd_req     (rd_req),
        .rd_addr    (rd_addr),
        .wr_req     (wr_req),
        .wr_addr    (wr_addr),
        .wr_data    (wr_data),
        .wr_be      (wr_be),
        .rd_data    (rd_data),
        .rd_valid   (rd_valid),
        .beat_phase (beat_phase)
    );

    task automatic chk(input bit ok, input string req, input logic [16:0] act, input logic [16:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h at edge %0d", req, act, exp, edge_cnt);
        end
    endtask

    function automatic logic [15:0] mrg(input logic [15:0] o, input logic [15:0] n, input logic [1:0] b);
        for (int i = 0; i < 2; i++) if (b[i]) o[i*8 +: 8] = n[i*8 +: 8];
        return o;
    endfunction

    // Monitor: pops the scoreboard at every beat sample point
    always @(negedge clk) begin
        if (run && !rst) begin
            if (q.size() > 0 && q[0].t == edge_cnt) begin
                exp_t e;
                e = q.pop_front();
                chk(rd_valid === 1'b1 && rd_data === e.d, e.tag, {rd_valid, rd_data}, {1'b1, e.d});
            end else begin
                chk(rd_valid === 1'b0 && rd_data === '0, "R7/R8 idle", {rd_valid, rd_data}, 17'h0);
            end
        end
    end

    task automatic sync_cmd();
        @(negedge clk);
        while (beat_phase !== 1'b0) @(negedge clk);
    endtask

    // Driver: one command period; must be entered at a negedge before a command edge
    task automatic cmd(input bit rv, input int ra, input bit wv, input int wa,
                       input logic [15:0] d0, input logic [1:0] b0,
                       input logic [15:0] d1, input logic [1:0] b1, input string tag);
        int n;
        n = edge_cnt + 1;
        rd_req = rv; rd_addr = AW'(ra);
        wr_req = wv; wr_addr = AW'(wa);
        wr_data = d0; wr_be = b0;
        if (wv) begin
            mlo[wa] = mrg(mlo[wa], d0, b0);
            mhi[wa] = mrg(mhi[wa], d1, b1);
        end
        if (rv) begin
            q.push_back('{n + 4, mlo[ra], tag});
            q.push_back('{n + 5, mhi[ra], tag});
        end
        @(negedge clk);
        rd_req = 1'b0; wr_req = 1'b0;
        wr_data = d1; wr_be = b1;
        @(negedge clk);
        wr_data = '0; wr_be = '0;
    endtask

    task automatic idle(input int periods);
        repeat (periods) cmd(0, 0, 0, 0, 16'h0, 2'b00, 16'h0, 2'b00, "");
    endtask

    initial begin
        repeat (4) @(negedge clk);
        chk(rd_valid === 1'b0 && rd_data === '0 && beat_phase === 1'b0, "R10 reset state",
            {rd_valid, rd_data}, 17'h0);
        rst = 1'b0;
        chk(beat_phase === 1'b0, "R11 first slot", {16'h0, beat_phase}, 17'h0);
        @(negedge clk);
        chk(beat_phase === 1'b1, "R11 tail slot", {16'h0, beat_phase}, 17'h1);
        @(negedge clk);
        chk(beat_phase === 1'b0, "R11 toggles", {16'h0, beat_phase}, 17'h0);
        run = 1'b1;

        // R2 R3: fill every word with full enables
        for (int a = 0; a < 16; a++)
            cmd(0, 0, 1, a, 16'h1000 + 16'(a), 2'b11, 16'h2000 + 16'(a), 2'b11, "");
        cmd(1, 3, 0, 0, 0, 0, 0, 0, "R3 beat order");
        cmd(1, 9, 0, 0, 0, 0, 0, 0, "R2 word store");
        idle(4);

        // R5: isolated read, latency
        cmd(1, 12, 0, 0, 0, 0, 0, 0, "R5 latency");
        idle(4);

        // R4: partial enables per beat
        cmd(0, 0, 1, 2, 16'hAAAA, 2'b01, 16'hBBBB, 2'b10, "");
        cmd(0, 0, 1, 4, 16'hCCCC, 2'b00, 16'hDDDD, 2'b01, "");
        cmd(1, 2, 0, 0, 0, 0, 0, 0, "R4 byte merge");
        cmd(1, 4, 0, 0, 0, 0, 0, 0, "R4 byte merge");
        idle(4);

        // R1 R6: same-slot read and write
        cmd(1, 7, 1, 7, 16'h7E7E, 2'b10, 16'h5A5A, 2'b11, "R6 same slot");
        cmd(1, 6, 1, 8, 16'h0808, 2'b11, 16'h8080, 2'b11, "R1 concurrent");
        cmd(1, 8, 0, 0, 0, 0, 0, 0, "R1 write landed");
        idle(4);
        // R6: read one slot before the write sees old data; read right after sees new
        cmd(1, 10, 0, 0, 0, 0, 0, 0, "R6 older read");
        cmd(1, 10, 1, 10, 16'hF00F, 2'b11, 16'h0FF0, 2'b01, "R6 pending write");
        idle(4);

        // R9: four consecutive reads
        cmd(1, 1, 0, 0, 0, 0, 0, 0, "R9 stream");
        cmd(1, 2, 0, 0, 0, 0, 0, 0, "R9 stream");
        cmd(1, 3, 0, 0, 0, 0, 0, 0, "R9 stream");
        cmd(1, 5, 0, 0, 0, 0, 0, 0, "R9 stream");
        idle(5);

        // R10: reset drops a half-assembled write and a fresh read, array survives
        sync_cmd();
        rd_req = 1'b1; rd_addr = 4'd5;
        wr_req = 1'b1; wr_addr = 4'd5; wr_data = 16'hDEAD; wr_be = 2'b11;
        @(negedge clk);
        rst = 1'b1; rd_req = 1'b0; wr_req = 1'b0; wr_data = 16'hBEEF;
        repeat (3) @(negedge clk);
        wr_data = '0; wr_be = '0;
        chk(rd_valid === 1'b0 && rd_data === '0 && beat_phase === 1'b0, "R10 in reset",
            {rd_valid, rd_data}, 17'h0);
        rst = 1'b0;
        idle(4);
        cmd(1, 5, 0, 0, 0, 0, 0, 0, "R10 array kept");
        idle(5);

        chk(q.size() == 0, "R7 all beats seen", 17'(q.size()), 17'h0);
        run = 1'b0;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        #250000;
        n_chk++;
        n_fail++;
        $display("FAIL watchdog: actual hung expected done");
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

endmodule